// File: doc/BRIEF.md
# Non-Volatile Memory Command Guard

This block sits in front of the programming engine of an on-chip non-volatile array. Software starts a program or erase by writing data to the target array location, which stores that address in an internal command-address register. A separate launch strobe then asks for the command to run. At launch the stored address is compared against a protection boundary. A protected target raises a protection-violation flag and nothing runs. A launch out of sequence raises an access-error flag. A valid launch runs a fixed-length busy period that stands in for the cell programming, and a completion flag is raised when that period ends.

The stored address can only come from an array write made since the last launch attempt. Array reads never touch it. At the end of every command the register is reset to a harmless value and the block is disarmed, so a leftover address from an earlier access can never decide the protection result. Both error flags are cleared by writing ones to their bit positions in the status register.

Top module: `nvm_cmd_guard`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `err_viol` and `err_access` are all 0 and no target is armed, so a launch issued right away is refused.
- R2: An array write while idle stores its address and arms the block. An array read never changes the stored address or the armed state, even when the read targets a protected location between the write and the launch.
- R3: With `prot_en` high, a launch whose stored address is at or above `prot_bound` sets `err_viol` one cycle later and never raises `busy`. An address one below the boundary runs normally.
- R4: With `prot_en` low, `err_viol` is never set, and any armed address launches.
- R5: A valid launch raises `busy` in the following cycle and keeps it high for exactly BUSY_CYC cycles. `done` is cleared at that launch and rises in the cycle `busy` falls. It then stays high until the next valid launch.
- R6: A launch while idle sets `err_access` and does not run in any of these cases: the block is not armed, `err_viol` is 1, or `err_access` is 1.
- R7: An array write or a launch while `busy` is high aborts the command. `err_access` is set, `busy` falls in the next cycle and `done` stays 0.
- R8: A status write (`stat_wr`) clears `err_viol` when bit 5 of `stat_wdata` is 1 and clears `err_access` when bit 4 is 1. Other bits are ignored. If a flag is set and cleared in the same cycle, the set wins.
- R9: Every launch attempt, command end or abort disarms the block. A later launch with no new array write sets `err_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_wr | input | 1 | Array data write strobe |
| arr_rd | input | 1 | Array read strobe |
| arr_addr | input | AW | Array address of the read or write |
| cmd_go | input | 1 | Command launch strobe |
| prot_en | input | 1 | Block-protection enable |
| prot_bound | input | AW | Lowest protected address |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data; bit 5 and bit 4 are write-1-to-clear |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command completed |
| err_viol | output | 1 | Protection-violation flag |
| err_access | output | 1 | Access-error flag |

## Verification
The bench builds the block with an 8-bit address and a busy period of 4 cycles. This keeps a whole command, its end and a mid-command abort within a few clocks. It also puts the protection boundary 0xC0 and its neighbour 0xBF within reach of directed writes. The short busy period also lets every error path be tried inside one run: an unarmed launch, a launch behind a set flag, and a read of a protected address between the write and the launch.

// File: rtl/nvm_guard_pkg.sv
// Package: shared constants for the command guard.
// Assumes an 8-bit status write word with the two error bits at 5 and 4.
package nvm_guard_pkg;
    localparam int STAT_W        = 8;
    localparam int STAT_VIOL_BIT = 5;
    localparam int STAT_ACC_BIT  = 4;

    // Sequencer state of the busy engine.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/nvm_addr_latch.sv
// Module: command-address register with its armed bit.
// Loads only on an accepted array write; reloads RST_ADDR at command end
// or abort. Assumes the caller never asserts take_wr and reload together.
module nvm_addr_latch #(
    parameter int          AW       = 16,
    parameter logic [AW-1:0] RST_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_wr,
    input  logic          reload,
    input  logic          launch_try,
    input  logic [AW-1:0] wr_addr,
    output logic [AW-1:0] lat_addr,
    output logic          armed
);
    // Stored target address: array write loads it, command end resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_addr <= RST_ADDR;
        else if (take_wr) lat_addr <= wr_addr;
        else if (reload)  lat_addr <= RST_ADDR;
    end

    // Armed bit: set by an accepted write, cleared by any launch or end.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed <= 1'b0;
        else if (take_wr)              armed <= 1'b1;
        else if (reload || launch_try) armed <= 1'b0;
    end

    // R9: a finished or aborted command leaves the block disarmed.
    assert_disarm_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !take_wr) |=> !armed);
endmodule

// File: rtl/nvm_prot_cmp.sv
// Module: protection comparator.
// PROT_FROM_TOP=1 protects addresses >= bound, else addresses < bound.
// Purely combinational; hit is low whenever protection is disabled.
module nvm_prot_cmp #(
    parameter int AW            = 16,
    parameter bit PROT_FROM_TOP = 1'b1
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] bound,
    output logic          hit
);
    generate
        if (PROT_FROM_TOP) begin : g_top
            // Upper region protected.
            always_comb hit = en && (addr >= bound);
        end else begin : g_bottom
            // Lower region protected.
            always_comb hit = en && (addr < bound);
        end
    endgenerate
endmodule

// File: rtl/nvm_cmd_seq.sv
// Module: launch decision, busy timer and status flags.
// Decides each launch from registered flags and the armed bit; counts the
// fixed busy period; handles write-1-to-clear with set-over-clear priority.
module nvm_cmd_seq
    import nvm_guard_pkg::*;
#(
    parameter int BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              arr_wr,
    input  logic              armed,
    input  logic              prot_hit,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              busy,
    output logic              done,
    output logic              err_viol,
    output logic              err_access,
    output logic              cmd_end,
    output logic              cmd_abort
);
    localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYC - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          try_go, refuse, viol_set, run_ok, acc_set;
    logic          viol_clr, acc_clr;

    // Launch decision and abort/end detection from registered state.
    always_comb begin
        try_go    = cmd_go && (state == SEQ_IDLE);
        refuse    = try_go && (err_viol || err_access || !armed);
        viol_set  = try_go && !refuse && prot_hit;
        run_ok    = try_go && !refuse && !prot_hit;
        cmd_abort = (state == SEQ_RUN) && (arr_wr || cmd_go);
        cmd_end   = (state == SEQ_RUN) && !cmd_abort && (cnt == '0);
        acc_set   = refuse || cmd_abort;
        viol_clr  = stat_wr && stat_wdata[STAT_VIOL_BIT];
        acc_clr   = stat_wr && stat_wdata[STAT_ACC_BIT];
    end

    // Busy engine: run for BUSY_CYC cycles, stop on end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else if (run_ok) begin
            state <= SEQ_RUN;
            cnt   <= CNT_LOAD;
        end else if (cmd_abort || cmd_end) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else if (state == SEQ_RUN) begin
            cnt   <= cnt - 1'b1;
        end
    end

    // Completion flag: cleared on a valid launch, set on a normal end.
    always_ff @(posedge clk) begin
        if (!rst_n)       done <= 1'b0;
        else if (run_ok)  done <= 1'b0;
        else if (cmd_end) done <= 1'b1;
    end

    // Error flags: write-1-to-clear, a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_viol   <= 1'b0;
            err_access <= 1'b0;
        end else begin
            err_viol   <= (err_viol && !viol_clr) || viol_set;
            err_access <= (err_access && !acc_clr) || acc_set;
        end
    end

    always_comb busy = (state == SEQ_RUN);

    // R6: busy only starts from an armed launch.
    assert_launch_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed && cmd_go));
    // R5: done only rises as busy falls.
    assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    // R7: an array write during a command aborts it with an access error.
    assert_abort_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arr_wr) |=> (!busy && err_access && !done));
    // R8: a clear of the violation bit with no launch leaves it low.
    assert_w1c_viol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata[STAT_VIOL_BIT] && !cmd_go) |=> !err_viol);
    // R3: a violation and a run never start together.
    assert_viol_no_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_viol) |-> !$rose(busy));
endmodule

// File: rtl/nvm_cmd_guard.sv
// Module: top of the non-volatile memory command guard.
// Ties the address register, protection comparator and sequencer together.
// Assumes all inputs are synchronous to clk.
module nvm_cmd_guard
    import nvm_guard_pkg::*;
#(
    parameter int            AW            = 16,
    parameter int            BUSY_CYC      = 8,
    parameter bit            PROT_FROM_TOP = 1'b1,
    parameter logic [AW-1:0] RST_ADDR      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_wr,
    input  logic              arr_rd,
    input  logic [AW-1:0]     arr_addr,
    input  logic              cmd_go,
    input  logic              prot_en,
    input  logic [AW-1:0]     prot_bound,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              busy,
    output logic              done,
    output logic              err_viol,
    output logic              err_access
);
    logic [AW-1:0] lat_addr;
    logic          armed, prot_hit, cmd_end, cmd_abort;
    logic          take_wr, launch_try, reload;

    // Strobe qualification shared by the sub-blocks.
    always_comb begin
        take_wr    = arr_wr && !busy;
        launch_try = cmd_go && !busy;
        reload     = cmd_end || cmd_abort;
    end

    nvm_addr_latch #(.AW(AW), .RST_ADDR(RST_ADDR)) u_latch (
        .clk(clk), .rst_n(rst_n), .take_wr(take_wr), .reload(reload),
        .launch_try(launch_try), .wr_addr(arr_addr),
        .lat_addr(lat_addr), .armed(armed)
    );

    nvm_prot_cmp #(.AW(AW), .PROT_FROM_TOP(PROT_FROM_TOP)) u_cmp (
        .en(prot_en), .addr(lat_addr), .bound(prot_bound), .hit(prot_hit)
    );

    nvm_cmd_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .arr_wr(arr_wr),
        .armed(armed), .prot_hit(prot_hit), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .busy(busy), .done(done),
        .err_viol(err_viol), .err_access(err_access),
        .cmd_end(cmd_end), .cmd_abort(cmd_abort)
    );

    // R2: a read alone never moves the stored command address.
    assert_read_no_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && !arr_wr && !reload) |=> $stable(lat_addr));
    // R4: a violation can only be raised with protection enabled.
    assert_no_viol_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_viol) |-> $past(prot_en));
endmodule

// File: tb/nvm_cmd_guard_tb_top.sv
module nvm_cmd_guard_tb_top;
    localparam int AW = 8;
    localparam int BC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arr_wr = 0, arr_rd = 0, cmd_go = 0, prot_en = 1, stat_wr = 0;
    logic [AW-1:0] arr_addr = '0, prot_bound = 8'hC0;
    logic [7:0] stat_wdata = '0;
    logic busy, done, err_viol, err_access;

    int checks = 0, errors = 0, cycles = 0;

    // Reference model state (behavioural).
    int m_lat, m_cnt;
    bit m_armed, m_busy, m_done, m_viol, m_acc;

    always #2 clk = ~clk;

    nvm_cmd_guard #(.AW(AW), .BUSY_CYC(BC)) dut_i (
        .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .arr_rd(arr_rd),
        .arr_addr(arr_addr), .cmd_go(cmd_go), .prot_en(prot_en),
        .prot_bound(prot_bound), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .busy(busy), .done(done), .err_viol(err_viol), .err_access(err_access)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model update at every rising edge.
    always @(posedge clk) begin
        bit sv, sa, go_ok;
        cycles++;
        if (!rst_n) begin
            m_lat = 0; m_cnt = 0; m_armed = 0; m_busy = 0;
            m_done = 0; m_viol = 0; m_acc = 0;
        end else begin
            sv = 0; sa = 0;
            if (m_busy) begin
                if (arr_wr || cmd_go) begin
                    sa = 1; m_busy = 0; m_armed = 0; m_lat = 0;
                end else if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_armed = 0; m_lat = 0;
                end else m_cnt--;
            end else begin
                if (cmd_go) begin
                    go_ok = !(m_viol || m_acc || !m_armed);
                    if (!go_ok) sa = 1;
                    else if (prot_en && m_lat >= int'(prot_bound)) sv = 1;
                    else begin m_busy = 1; m_cnt = BC - 1; m_done = 0; end
                    m_armed = 0;
                end
                if (arr_wr) begin m_lat = int'(arr_addr); m_armed = 1; end
            end
            if (stat_wr && stat_wdata[5]) m_viol = 0;
            if (stat_wr && stat_wdata[4]) m_acc = 0;
            if (sv) m_viol = 1;
            if (sa) m_acc = 1;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk("R5 busy (model)", busy, m_busy);
            chk("R5 done (model)", done, m_done);
            chk("R3 err_viol (model)", err_viol, m_viol);
            chk("R6 err_access (model)", err_access, m_acc);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [AW-1:0] a);
        arr_wr = 1; arr_addr = a; @(negedge clk); arr_wr = 0;
    endtask
    task automatic rd(input logic [AW-1:0] a);
        arr_rd = 1; arr_addr = a; @(negedge clk); arr_rd = 0;
    endtask
    task automatic go();
        cmd_go = 1; @(negedge clk); cmd_go = 0;
    endtask
    task automatic sclr(input logic [7:0] d);
        stat_wr = 1; stat_wdata = d; @(negedge clk); stat_wr = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        // R1: reset state and an unarmed launch.
        chk("R1 busy", busy, 0); chk("R1 done", done, 0);
        chk("R1 viol", err_viol, 0); chk("R1 acc", err_access, 0);
        go();
        chk("R1 unarmed launch acc", err_access, 1);
        chk("R1 unarmed launch busy", busy, 0);
        // R8: unrelated bits do not clear; bit 4 does.
        sclr(8'hCF);
        chk("R8 other bits ignored", err_access, 1);
        sclr(8'h10);
        chk("R8 acc cleared", err_access, 0);
        // R5: normal command timing.
        wr(8'h20); go();
        chk("R5 busy first", busy, 1);
        idle(BC - 1);
        chk("R5 busy last", busy, 1);
        idle(1);
        chk("R5 busy fell", busy, 0); chk("R5 done", done, 1);
        // R3: protected target and boundary.
        wr(8'hC0); go();
        chk("R3 viol at bound", err_viol, 1); chk("R3 no busy", busy, 0);
        // R6: launch behind a set flag.
        wr(8'h10); go();
        chk("R6 flag blocks launch", err_access, 1); chk("R6 no busy", busy, 0);
        sclr(8'h30);
        chk("R8 both cleared viol", err_viol, 0);
        chk("R8 both cleared acc", err_access, 0);
        wr(8'hBF); go();
        chk("R3 bound-1 runs", busy, 1); chk("R3 bound-1 no viol", err_viol, 0);
        idle(BC);
        // R2: read of a protected location between write and launch.
        wr(8'h10); rd(8'hF0); rd(8'hC0); go();
        chk("R2 read ignored runs", busy, 1); chk("R2 no viol", err_viol, 0);
        idle(BC);
        chk("R5 done again", done, 1);
        // R9: launch after end without a new write.
        go();
        chk("R9 stale launch acc", err_access, 1); chk("R9 no busy", busy, 0);
        sclr(8'h10);
        // R4: protection disabled.
        prot_en = 0;
        wr(8'hF0); go();
        chk("R4 runs unprotected", busy, 1); chk("R4 no viol", err_viol, 0);
        idle(BC);
        prot_en = 1;
        // R7: abort by array write, then by launch.
        wr(8'h30); go(); idle(1);
        wr(8'h31);
        chk("R7 abort busy", busy, 0); chk("R7 abort acc", err_access, 1);
        chk("R7 abort done", done, 0);
        sclr(8'h10);
        go();
        chk("R9 abort disarms", err_access, 1);
        sclr(8'h10);
        wr(8'h40); go(); go();
        chk("R7 launch abort busy", busy, 0); chk("R7 launch abort acc", err_access, 1);
        // R8: set wins over clear in the same cycle.
        sclr(8'h10);
        cmd_go = 1; stat_wr = 1; stat_wdata = 8'h10; @(negedge clk);
        cmd_go = 0; stat_wr = 0;
        chk("R8 set wins", err_access, 1);
        sclr(8'h30);
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule